// File: doc/BRIEF.md
# Interrupt Error Status Register

This block detects and reports errors for a local interrupt controller. Five kinds of fault are tracked: an accept failure on the send side and one on the receive side, an illegal vector on send and one on receive, and any access to a register address that does not exist. Faults first gather in a hidden accumulator. Software sees them only after it writes the status register. That write moves the accumulated set into the visible register and empties the accumulator. The usual sequence is therefore a write followed by a read.

The block also holds the vector-table entries: one error entry and a parameterised number of other entries. Each entry has a vector and a mask bit. Any entry written with a vector below 16 is itself recorded as a receive-side illegal-vector fault. This happens even when the entry is masked, and the written value is still stored. The error entry drives an interrupt request whenever the accumulator goes from empty to non-empty while that entry is unmasked.

The controller tracking the accumulator has two states. ST_EMPTY means no fault is pending. ST_HELD means at least one fault has been gathered since the last status write. The transitions are as follows:
- EMPTY to HELD on any new fault.
- HELD to EMPTY on a status write in a cycle with no new fault.
- HELD stays HELD otherwise, including a status write that coincides with a new fault.

Top module: `esr_unit`

Register map (default parameters): address 0 is the status register. Address 1 is the error entry. Addresses 2 to 6 are the other entries. Addresses 7 to 15 are unimplemented. An entry reads as its vector in bits 7:0 and its mask in bit 16.

## Requirements
- R1: After reset, the status register reads 0, every entry reads 0x0001_0000 (masked, vector 0), and irq is low.
- R2: The fault bits in the status register are: bit 2 send accept, bit 3 receive accept, bit 5 send illegal vector, bit 6 receive illegal vector, bit 7 illegal register address. Bits 0, 1, 4 and 31:8 always read 0.
- R3: A fault is not visible until the status register is written. A status write copies all faults gathered since the previous status write into the visible register and empties the accumulator. The visible register changes on no other event.
- R4: Two successive status writes with no fault in between leave the status register reading 0, so no stale bits remain after the error entry is enabled.
- R5: A fault arriving in the same cycle as a status write is not part of the copied value. It becomes visible at the following status write.
- R6: A read or write to an unimplemented address (1 + number of entries or above) records bit 7.
- R7: Writing any entry with a vector in 0..15 records bit 6, even when the written mask bit is set. The written value is stored and read back unchanged.
- R8: When the error entry is unmasked, a fault that enters an empty accumulator raises irq for exactly one cycle, in the cycle after the fault. A status write counts as emptying the accumulator. irq_vector carries the error entry's vector.
- R9: While the error entry is masked, no irq is raised, but faults are still gathered and become visible.
- R10: No irq is raised for faults that arrive while the accumulator is already non-empty and no status write occurs.
- R11: The data value of a status write has no effect on what becomes visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | Access is a write when high |
| acc_addr | input | ADDR_W | Register address |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Read data for the current access |
| ev_send_accept | input | 1 | Send accept fault pulse |
| ev_recv_accept | input | 1 | Receive accept fault pulse |
| ev_send_illegal | input | 1 | Send illegal vector fault pulse |
| ev_recv_illegal | input | 1 | Receive illegal vector fault pulse |
| ev_bad_reg | input | 1 | External illegal register address fault pulse |
| irq | output | 1 | Error interrupt request, one cycle |
| irq_vector | output | 8 | Vector of the error entry |

## Verification
A status write and a new fault can land on the same clock edge. In that cycle the copy into the visible register and the reload of the accumulator happen together. The bench provokes this by holding a receive-accept fault during a status write while an earlier send-illegal fault is pending. It then judges three things: the status read shows only the earlier fault; the later fault appears only after the next write; and an interrupt is raised because the write emptied the accumulator.

// File: rtl/esr_pkg.sv
package esr_pkg;
    localparam int ERR_W  = 8;
    localparam int VEC_W  = 8;
    localparam int B_SACC = 2;
    localparam int B_RACC = 3;
    localparam int B_SVEC = 5;
    localparam int B_RVEC = 6;
    localparam int B_ADDR = 7;
    localparam logic [ERR_W-1:0] RSVD_MASK = 8'h13;

    typedef enum logic {
        ST_EMPTY,
        ST_HELD
    } acc_state_e;
endpackage

// File: rtl/esr_decode.sv
module esr_decode #(
    parameter int ADDR_W  = 4,
    parameter int NUM_ENT = 6
) (
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit_status,
    output logic [NUM_ENT-1:0] hit_ent,
    output logic              bad_addr
);
    assign hit_status = acc_en && (acc_addr == '0);

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_hit
        assign hit_ent[i] = acc_en && (acc_addr == ADDR_W'(i + 1));
    end

    assign bad_addr = acc_en && !hit_status && !(|hit_ent);
endmodule

// File: rtl/esr_vtable.sv
module esr_vtable #(
    parameter int DATA_W   = 32,
    parameter int NUM_ENT  = 6,
    parameter int MASK_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_wr,
    input  logic [NUM_ENT-1:0] hit_ent,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  ent_rdata,
    output logic [esr_pkg::VEC_W-1:0] err_vec,
    output logic               err_mask,
    output logic               low_vec_wr
);
    import esr_pkg::*;

    logic [VEC_W-1:0] vec_q  [NUM_ENT];
    logic             mask_q [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[i]  <= '0;
                mask_q[i] <= 1'b1;
            end else if (acc_wr && hit_ent[i]) begin
                vec_q[i]  <= acc_wdata[VEC_W-1:0];
                mask_q[i] <= acc_wdata[MASK_BIT];
            end
        end
    end

    always_comb begin
        ent_rdata = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_ent[i]) begin
                ent_rdata[VEC_W-1:0] = vec_q[i];
                ent_rdata[MASK_BIT]  = mask_q[i];
            end
        end
    end

    assign err_vec    = vec_q[0];
    assign err_mask   = mask_q[0];
    assign low_vec_wr = acc_wr && (|hit_ent) && (acc_wdata[VEC_W-1:4] == '0);
endmodule

// File: rtl/esr_collect.sv
module esr_collect (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [esr_pkg::ERR_W-1:0] new_err,
    input  logic                     clear,
    input  logic                     mask,
    output logic [esr_pkg::ERR_W-1:0] visible,
    output logic                     irq
);
    import esr_pkg::*;

    acc_state_e       state_q, state_d;
    logic [ERR_W-1:0] acc_q, visible_q;
    logic             irq_q;
    logic             has_new, fresh;

    assign has_new = |new_err;
    assign fresh   = (state_q == ST_EMPTY) || clear;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (has_new)           state_d = ST_HELD;
            ST_HELD:  if (clear && !has_new) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            acc_q     <= '0;
            visible_q <= '0;
        end else begin
            state_q <= state_d;
            if (clear) begin
                visible_q <= acc_q;
                acc_q     <= new_err;
            end else begin
                acc_q <= acc_q | new_err;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= fresh && has_new && !mask;
    end

    assign visible = visible_q;
    assign irq     = irq_q;

    p_visible_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(visible_q));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ((visible_q & RSVD_MASK) == '0));
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !$past(mask));
    p_single_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !clear) |=> !irq_q);
    p_addr_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        new_err[B_ADDR] |=> acc_q[B_ADDR]);
endmodule

// File: rtl/esr_unit.sv
module esr_unit #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int NUM_OTHER = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              ev_send_accept,
    input  logic              ev_recv_accept,
    input  logic              ev_send_illegal,
    input  logic              ev_recv_illegal,
    input  logic              ev_bad_reg,
    output logic              irq,
    output logic [7:0]        irq_vector
);
    import esr_pkg::*;

    localparam int NUM_ENT  = NUM_OTHER + 1;
    localparam int MASK_BIT = 16;

    logic               hit_status, dec_bad, low_vec_wr, err_mask;
    logic [NUM_ENT-1:0] hit_ent;
    logic [DATA_W-1:0]  ent_rdata;
    logic [VEC_W-1:0]   err_vec;
    logic [ERR_W-1:0]   new_err, visible;

    esr_decode #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT)) u_dec (
        .acc_en(acc_en), .acc_addr(acc_addr), .hit_status(hit_status),
        .hit_ent(hit_ent), .bad_addr(dec_bad)
    );

    esr_vtable #(.DATA_W(DATA_W), .NUM_ENT(NUM_ENT), .MASK_BIT(MASK_BIT)) u_tbl (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .hit_ent(hit_ent),
        .acc_wdata(acc_wdata), .ent_rdata(ent_rdata), .err_vec(err_vec),
        .err_mask(err_mask), .low_vec_wr(low_vec_wr)
    );

    always_comb begin
        new_err         = '0;
        new_err[B_SACC] = ev_send_accept;
        new_err[B_RACC] = ev_recv_accept;
        new_err[B_SVEC] = ev_send_illegal;
        new_err[B_RVEC] = ev_recv_illegal || low_vec_wr;
        new_err[B_ADDR] = ev_bad_reg || dec_bad;
    end

    esr_collect u_col (
        .clk(clk), .rst_n(rst_n), .new_err(new_err),
        .clear(acc_wr && hit_status), .mask(err_mask),
        .visible(visible), .irq(irq)
    );

    always_comb begin
        acc_rdata = '0;
        if (hit_status)    acc_rdata[ERR_W-1:0] = visible;
        else if (|hit_ent) acc_rdata = ent_rdata;
    end

    assign irq_vector = err_vec;

    p_entry_rst_r1: assert property (@(posedge clk)
        !rst_n |=> err_mask);
endmodule

// File: tb/esr_unit_test.sv
module esr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [4:0]  ev = '0;
    logic        irq;
    logic [7:0]  irq_vector;
    int          n_run = 0, n_fail = 0, irq_cnt = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    esr_unit uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ev_send_accept(ev[0]), .ev_recv_accept(ev[1]),
        .ev_send_illegal(ev[2]), .ev_recv_illegal(ev[3]), .ev_bad_reg(ev[4]),
        .irq(irq), .irq_vector(irq_vector)
    );

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    // rows: {events bad,rvec,svec,racc,sacc ; expected status}
    localparam logic [12:0] ROWS [8] = '{
        {5'b00001, 8'h04}, {5'b00010, 8'h08}, {5'b00100, 8'h20},
        {5'b01000, 8'h40}, {5'b10000, 8'h80}, {5'b00011, 8'h0C},
        {5'b11111, 8'hEC}, {5'b10101, 8'hA4}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_en = 1; acc_wr = 0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 0;
    endtask

    task automatic pulse(logic [4:0] e);
        @(negedge clk);
        ev = e;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, r); chk("R1 status", r, 0);
        rd(1, r); chk("R1 error entry", r, 32'h0001_0000);
        rd(4, r); chk("R1 other entry", r, 32'h0001_0000);
        chk("R1 irq", {31'b0, irq}, 0);

        // table: R2 bit map, R3 write-to-latch, R9 masked quiet
        for (int i = 0; i < 8; i++) begin
            logic [7:0] prev;
            prev = (i == 0) ? 8'h00 : ROWS[i-1][7:0];
            base = irq_cnt;
            pulse(ROWS[i][12:8]);
            rd(0, r); chk("R3 hidden before write", r, {24'b0, prev});
            wr(0, 0);
            rd(0, r); chk("R2 R3 status", r, {24'b0, ROWS[i][7:0]});
            chk("R9 masked no irq", irq_cnt - base, 0);
        end

        // R6 unimplemented address, read and write
        rd(9, r); wr(0, 0);
        rd(0, r); chk("R6 bad read", r, 32'h80);
        wr(15, 32'h1234); wr(0, 0);
        rd(0, r); chk("R6 bad write", r, 32'h80);

        // R7 low vector into masked entry
        wr(3, 32'h0001_0005); wr(0, 0);
        rd(0, r); chk("R7 low vector flagged", r, 32'h40);
        rd(3, r); chk("R7 stored", r, 32'h0001_0005);
        wr(3, 32'h0000_0020); wr(0, 0);
        rd(0, r); chk("R7 legal vector clean", r, 0);

        // R4 enable error entry then clear twice
        wr(1, 32'h0000_0040);
        wr(0, 0); wr(0, 0);
        rd(0, r); chk("R4 no stale", r, 0);

        // R8 one-cycle irq with vector
        @(negedge clk); ev = 5'b00001;
        @(negedge clk); ev = '0;
        chk("R8 irq high", {31'b0, irq}, 1);
        chk("R8 vector", {24'b0, irq_vector}, 32'h40);
        @(negedge clk);
        chk("R8 irq one cycle", {31'b0, irq}, 0);

        // R10 no re-raise while held
        base = irq_cnt;
        pulse(5'b00010);
        chk("R10 no second irq", irq_cnt - base, 0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, r); chk("R11 R2 write data ignored", r, 32'h0C);

        // R5 same-cycle fault and status write
        pulse(5'b00100);
        base = irq_cnt;
        @(negedge clk);
        acc_en = 1; acc_wr = 1; acc_addr = 0; acc_wdata = 0; ev = 5'b00010;
        @(negedge clk);
        acc_en = 0; acc_wr = 0; ev = '0;
        chk("R8 irq after clearing write", irq_cnt - base, 1);
        rd(0, r); chk("R5 excluded", r, 32'h20);
        wr(0, 0);
        rd(0, r); chk("R5 next write", r, 32'h08);

        // R9 masked error entry
        wr(1, 32'h0001_0040);
        base = irq_cnt;
        pulse(5'b00001);
        wr(0, 0);
        rd(0, r); chk("R9 gathered while masked", r, 32'h04);
        chk("R9 no irq", irq_cnt - base, 0);

        finish_run();
    end
endmodule